// File: doc/BRIEF.md
# Wide-Bank Cartridge Memory Mapper

This block sits between an 8-bit CPU bus with 16-bit addresses and the ROM and RAM of a cartridge. CPU writes to the low half of the address space never reach the ROM. They load the mapper's control state instead: a RAM enable flag, a 9-bit ROM bank number and a 4-bit RAM bank number. The 9-bit ROM bank is loaded through two separate write windows. One window takes the low eight bits and the other takes the top bit.

CPU reads and writes are translated combinationally into a flat ROM address (up to 512 banks of 16 KiB) and a flat RAM address (up to 16 banks of 8 KiB), each with its own chip select. The block also drives a read-data mux back to the CPU. Two parameters set how many ROM and RAM banks are actually fitted. A bank at or beyond the fitted count is never selected. Reads from such a bank return zero and writes to it are dropped. Setting the RAM count to zero removes the RAM bank register.

Top module: `wbank_mapper`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0 and RAM enable is low. A read at 0x4000 therefore gives ROM address 0x04000, and a read at 0xA000 gives RAM address 0x00000.
- R2: A write anywhere in 0x0000–0x1FFF sets RAM enable when the data byte is 0x0A and clears it for any other byte.
- R3: A write in 0x2000–0x2FFF loads ROM bank bits 7:0 with the whole data byte and leaves bank bit 8 unchanged.
- R4: A write in 0x3000–0x3FFF loads ROM bank bit 8 from data bit 0 and leaves bank bits 7:0 unchanged.
- R5: Loading 0 into the ROM bank selects bank 0 in the switchable window. No value is remapped.
- R6: When RAM is fitted, a write in 0x4000–0x5FFF loads the RAM bank with data bits 3:0.
- R7: A read in 0x0000–0x3FFF drives ROM address = CPU address (fixed bank 0), whatever the bank register holds.
- R8: A read in 0x4000–0x7FFF drives ROM address = bank × 0x4000 + (address − 0x4000).
- R9: A ROM read in the switchable window while the bank is at or beyond the fitted ROM count keeps the ROM chip select low and returns 0x00.
- R10: The RAM chip select rises only for a read or write in 0xA000–0xBFFF, with RAM address = RAM bank × 0x2000 + (address − 0xA000). The RAM write strobe rises only on writes there. A RAM read returns the RAM data.
- R11: While the RAM bank is at or beyond the fitted RAM count, RAM accesses keep both the chip select and the write strobe low, and reads return 0x00.
- R12: Writes at 0x6000 and above change none of the bank registers or the RAM enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe, one write per cycle |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data returned to the CPU (0x00 when nothing is selected) |
| rom_rdata | input | 8 | Data from the ROM array |
| ram_rdata | input | 8 | Data from the RAM array |
| rom_addr | output | 23 | Flat ROM byte address |
| rom_cs | output | 1 | ROM chip select |
| ram_addr | output | 17 | Flat RAM byte address |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write strobe |
| ram_en | output | 1 | RAM enable flag |

## Verification
The assertions check several properties on every cycle:
- the response of the enable flag and of both ROM bank fields to register writes,
- that the registers stay unchanged after writes at 0x6000 and above,
- that the RAM select stays inside its window,
- that no out-of-range ROM read or RAM write gets through.

The exact translated addresses, the reset values, the reach of bank 0 in the switchable window and the data mux can only be shown by the bench's scenarios. There, a behavioural model predicts every output on every cycle.

// File: rtl/wbank_pkg.sv
package wbank_pkg;
  localparam int ROM_BANK_W = 9;
  localparam int RAM_BANK_W = 4;
  localparam int ROM_OFS_W  = 14;
  localparam int RAM_OFS_W  = 13;
  localparam logic [7:0] RAM_EN_KEY = 8'h0A;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RAM_EN,
    SEL_ROM_LO,
    SEL_ROM_HI,
    SEL_RAM_BANK
  } reg_sel_e;

  // Register window from address bits 15:12
  function automatic reg_sel_e decode_reg(input logic [3:0] nib);
    case (nib)
      4'h0, 4'h1: decode_reg = SEL_RAM_EN;
      4'h2:       decode_reg = SEL_ROM_LO;
      4'h3:       decode_reg = SEL_ROM_HI;
      4'h4, 4'h5: decode_reg = SEL_RAM_BANK;
      default:    decode_reg = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/wbank_rst_sync.sv
module wbank_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/wbank_regs.sv
module wbank_regs
  import wbank_pkg::*;
#(
  parameter bit HAS_RAM = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [3:0]            addr_hi,
  input  logic [7:0]            wdata,
  output logic [ROM_BANK_W-1:0] rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  ram_en
);
  localparam logic [ROM_BANK_W-1:0] ROM_BANK_RST = ROM_BANK_W'(1);

  reg_sel_e              sel;
  logic                  en_load, lo_load, hi_load, rb_load;
  logic                  ram_en_d;
  logic [ROM_BANK_W-1:0] rom_bank_d;

  always_comb begin
    sel     = decode_reg(addr_hi);
    en_load = wr_en && (sel == SEL_RAM_EN);
    lo_load = wr_en && (sel == SEL_ROM_LO);
    hi_load = wr_en && (sel == SEL_ROM_HI);
    rb_load = wr_en && (sel == SEL_RAM_BANK);
  end

  always_comb begin
    ram_en_d   = (wdata == RAM_EN_KEY);
    rom_bank_d = rom_bank;
    if (lo_load) rom_bank_d[7:0] = wdata;
    if (hi_load) rom_bank_d[8]   = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_en   <= 1'b0;
      rom_bank <= ROM_BANK_RST;
    end else begin
      if (en_load)            ram_en   <= ram_en_d;
      if (lo_load || hi_load) rom_bank <= rom_bank_d;
    end
  end

  generate
    if (HAS_RAM) begin : g_ram_bank
      logic [RAM_BANK_W-1:0] ram_bank_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ram_bank_q <= '0;
        else if (rb_load) ram_bank_q <= wdata[RAM_BANK_W-1:0];
      end
      assign ram_bank = ram_bank_q;
    end else begin : g_no_ram_bank
      logic unused_rb;
      assign unused_rb = rb_load;
      assign ram_bank  = '0;
    end
  endgenerate
endmodule

// File: rtl/wbank_xlate.sv
module wbank_xlate
  import wbank_pkg::*;
#(
  parameter int unsigned ROM_BANKS_FITTED = 64,
  parameter int unsigned RAM_BANKS_FITTED = 4
) (
  input  logic                            cpu_rd,
  input  logic                            cpu_wr,
  input  logic [15:0]                     cpu_addr,
  input  logic [ROM_BANK_W-1:0]           rom_bank,
  input  logic [RAM_BANK_W-1:0]           ram_bank,
  input  logic [7:0]                      rom_rdata,
  input  logic [7:0]                      ram_rdata,
  output logic [ROM_BANK_W+ROM_OFS_W-1:0] rom_addr,
  output logic                            rom_cs,
  output logic [RAM_BANK_W+RAM_OFS_W-1:0] ram_addr,
  output logic                            ram_cs,
  output logic                            ram_we,
  output logic [7:0]                      cpu_rdata
);
  localparam int ROM_LIM_W = ROM_BANK_W + 1;
  localparam int RAM_LIM_W = RAM_BANK_W + 1;
  localparam logic [ROM_LIM_W-1:0] ROM_LIMIT = ROM_LIM_W'(ROM_BANKS_FITTED);
  localparam logic [RAM_LIM_W-1:0] RAM_LIMIT = RAM_LIM_W'(RAM_BANKS_FITTED);

  logic                  in_switch, rom_ok, ram_win, ram_ok;
  logic [ROM_BANK_W-1:0] eff_bank;

  always_comb begin
    in_switch = cpu_addr[14];
    rom_ok    = ({1'b0, rom_bank} < ROM_LIMIT);
    ram_ok    = ({1'b0, ram_bank} < RAM_LIMIT);
    ram_win   = (cpu_addr[15:13] == 3'b101);
    eff_bank  = in_switch ? rom_bank : '0;
    rom_addr  = {eff_bank, cpu_addr[ROM_OFS_W-1:0]};
    ram_addr  = {ram_bank, cpu_addr[RAM_OFS_W-1:0]};
    rom_cs    = cpu_rd && !cpu_addr[15] && (!in_switch || rom_ok);
    ram_cs    = (cpu_rd || cpu_wr) && ram_win && ram_ok;
    ram_we    = cpu_wr && ram_win && ram_ok;
    if (rom_cs)                cpu_rdata = rom_rdata;
    else if (ram_cs && cpu_rd) cpu_rdata = ram_rdata;
    else                       cpu_rdata = 8'h00;
  end
endmodule

// File: rtl/wbank_mapper.sv
module wbank_mapper
  import wbank_pkg::*;
#(
  parameter int unsigned ROM_BANKS_FITTED = 64,
  parameter int unsigned RAM_BANKS_FITTED = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  input  logic [7:0]  rom_rdata,
  input  logic [7:0]  ram_rdata,
  output logic [22:0] rom_addr,
  output logic        rom_cs,
  output logic [16:0] ram_addr,
  output logic        ram_cs,
  output logic        ram_we,
  output logic        ram_en
);
  localparam bit HAS_RAM = (RAM_BANKS_FITTED > 0);

  logic                  rst_sync_n;
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [RAM_BANK_W-1:0] ram_bank;

  wbank_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wbank_regs #(.HAS_RAM(HAS_RAM)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (cpu_wr),
    .addr_hi  (cpu_addr[15:12]),
    .wdata    (cpu_wdata),
    .rom_bank (rom_bank),
    .ram_bank (ram_bank),
    .ram_en   (ram_en)
  );

  wbank_xlate #(
    .ROM_BANKS_FITTED (ROM_BANKS_FITTED),
    .RAM_BANKS_FITTED (RAM_BANKS_FITTED)
  ) u_xlate (
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .rom_bank  (rom_bank),
    .ram_bank  (ram_bank),
    .rom_rdata (rom_rdata),
    .ram_rdata (ram_rdata),
    .rom_addr  (rom_addr),
    .rom_cs    (rom_cs),
    .ram_addr  (ram_addr),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .cpu_rdata (cpu_rdata)
  );
endmodule

// File: rtl/wbank_mapper_chk.sv
module wbank_mapper_chk
  import wbank_pkg::*;
#(
  parameter int unsigned ROM_BANKS_FITTED = 64,
  parameter int unsigned RAM_BANKS_FITTED = 4
) (
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic                  cpu_rd,
  input logic                  cpu_wr,
  input logic [15:0]           cpu_addr,
  input logic [7:0]            cpu_wdata,
  input logic [7:0]            cpu_rdata,
  input logic [ROM_BANK_W-1:0] rom_bank,
  input logic [RAM_BANK_W-1:0] ram_bank,
  input logic                  rom_cs,
  input logic                  ram_cs,
  input logic                  ram_we,
  input logic                  ram_en
);
  localparam int ROM_LIM_W = ROM_BANK_W + 1;
  localparam int RAM_LIM_W = RAM_BANK_W + 1;
  localparam logic [ROM_LIM_W-1:0] ROM_LIMIT = ROM_LIM_W'(ROM_BANKS_FITTED);
  localparam logic [RAM_LIM_W-1:0] RAM_LIMIT = RAM_LIM_W'(RAM_BANKS_FITTED);

  AST_RAMEN_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_wr && (cpu_addr[15:13] == 3'b000) && (cpu_wdata == RAM_EN_KEY) |=> ram_en); // R2
  AST_RAMEN_CLR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_wr && (cpu_addr[15:13] == 3'b000) && (cpu_wdata != RAM_EN_KEY) |=> !ram_en); // R2
  AST_ROM_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_wr && (cpu_addr[15:12] == 4'h2) |=>
      (rom_bank[7:0] == $past(cpu_wdata)) && (rom_bank[8] == $past(rom_bank[8]))); // R3
  AST_ROM_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_wr && (cpu_addr[15:12] == 4'h3) |=>
      (rom_bank[8] == $past(cpu_wdata[0])) && (rom_bank[7:0] == $past(rom_bank[7:0]))); // R4
  AST_ROM_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_rd && (cpu_addr[15:14] == 2'b01) && ({1'b0, rom_bank} >= ROM_LIMIT) |->
      !rom_cs && (cpu_rdata == 8'h00)); // R9
  AST_RAM_CS_WINDOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ram_cs |-> (cpu_addr[15:13] == 3'b101) && (cpu_rd || cpu_wr)); // R10
  AST_RAM_OOR_DROP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ram_we |-> ({1'b0, ram_bank} < RAM_LIMIT)); // R11
  AST_HIGH_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_wr && (cpu_addr >= 16'h6000) |=>
      $stable(rom_bank) && $stable(ram_bank) && $stable(ram_en)); // R12
endmodule

bind wbank_mapper wbank_mapper_chk #(
  .ROM_BANKS_FITTED (ROM_BANKS_FITTED),
  .RAM_BANKS_FITTED (RAM_BANKS_FITTED)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cpu_rd     (cpu_rd),
  .cpu_wr     (cpu_wr),
  .cpu_addr   (cpu_addr),
  .cpu_wdata  (cpu_wdata),
  .cpu_rdata  (cpu_rdata),
  .rom_bank   (rom_bank),
  .ram_bank   (ram_bank),
  .rom_cs     (rom_cs),
  .ram_cs     (ram_cs),
  .ram_we     (ram_we),
  .ram_en     (ram_en)
);

// File: tb/tb_wbank_mapper.sv
module tb_wbank_mapper;
  localparam int ROMN = 64;
  localparam int RAMN = 4;
  localparam logic [7:0] ROM_PAT = 8'hA5;
  localparam logic [7:0] RAM_PAT = 8'h3C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_rd, cpu_wr;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic [7:0]  rom_rdata, ram_rdata;
  logic [22:0] rom_addr;
  logic [16:0] ram_addr;
  logic        rom_cs, ram_cs, ram_we, ram_en;

  int checks = 0;
  int fails  = 0;

  // behavioural model state
  int m_rom, m_ram;
  bit m_en;

  always #4 clk = ~clk;

  wbank_mapper #(.ROM_BANKS_FITTED(ROMN), .RAM_BANKS_FITTED(RAMN)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .rom_addr(rom_addr),
    .rom_cs(rom_cs), .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we),
    .ram_en(ram_en)
  );

  function automatic bit fld(string tag, string name, int act, int exp);
    if (act != exp) begin
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, name, act, exp);
      return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic compare(string tag);
    int  a;
    bit  rd, wr, bad, e_rom_cs, e_ram_cs, e_we, ram_win;
    int  e_rdata;
    a        = int'(cpu_addr);
    rd       = cpu_rd;
    wr       = cpu_wr;
    ram_win  = (a >= 'hA000) && (a <= 'hBFFF);
    e_rom_cs = rd && (a < 'h8000) && ((a < 'h4000) || (m_rom < ROMN));
    e_ram_cs = (rd || wr) && ram_win && (m_ram < RAMN);
    e_we     = wr && ram_win && (m_ram < RAMN);
    e_rdata  = e_rom_cs ? int'(ROM_PAT) : ((e_ram_cs && rd) ? int'(RAM_PAT) : 0);
    bad = 1'b0;
    bad |= fld(tag, "ram_en", int'(ram_en), int'(m_en));
    bad |= fld(tag, "rom_cs", int'(rom_cs), int'(e_rom_cs));
    bad |= fld(tag, "ram_cs", int'(ram_cs), int'(e_ram_cs));
    bad |= fld(tag, "ram_we", int'(ram_we), int'(e_we));
    bad |= fld(tag, "cpu_rdata", int'(cpu_rdata), e_rdata);
    if (rd && a < 'h8000)
      bad |= fld(tag, "rom_addr", int'(rom_addr),
                 (a < 'h4000) ? a : m_rom * 'h4000 + (a - 'h4000));
    if (ram_win)
      bad |= fld(tag, "ram_addr", int'(ram_addr), m_ram * 'h2000 + (a - 'hA000));
    checks++;
    if (bad) fails++;
  endtask

  task automatic model_write(int a, int d);
    if (a < 'h2000)                    m_en  = (d == 'h0A);
    else if (a < 'h3000)               m_rom = (m_rom & 'h100) | d;
    else if (a < 'h4000)               m_rom = (m_rom & 'hFF) | ((d & 1) << 8);
    else if (a < 'h6000)               m_ram = d & 'hF;
  endtask

  task automatic step(bit rd, bit wr, int a, int d, string tag);
    @(negedge clk);
    cpu_rd    = rd;
    cpu_wr    = wr;
    cpu_addr  = a[15:0];
    cpu_wdata = d[7:0];
    #1 compare(tag);
    @(posedge clk);
    if (!rst_n) begin
      m_rom = 1; m_ram = 0; m_en = 1'b0;
    end else if (wr) begin
      model_write(a, d);
    end
  endtask

  task automatic rd_at(int a, string tag);  step(1'b1, 1'b0, a, 0, tag); endtask
  task automatic wr_at(int a, int d, string tag); step(1'b0, 1'b1, a, d, tag); endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    rom_rdata = ROM_PAT; ram_rdata = RAM_PAT;
    m_rom = 1; m_ram = 0; m_en = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 0, 0, "R1 reset");
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 0, 0, "R1 release");
    // R1 reset state
    rd_at('h4000, "R1");
    rd_at('hA000, "R1");
    // R7 fixed window
    rd_at('h0000, "R7");
    rd_at('h3FFF, "R7");
    // R2 enable key
    wr_at('h0000, 'h0A, "R2");
    step(1'b0, 1'b0, 0, 0, "R2");
    wr_at('h1FFF, 'h0B, "R2");
    step(1'b0, 1'b0, 0, 0, "R2");
    wr_at('h1000, 'h0A, "R2");
    // R3 low byte, R8 switchable mapping
    wr_at('h2000, 'h25, "R3");
    rd_at('h7FFF, "R8");
    rd_at('h4001, "R8");
    rd_at('h1234, "R7");
    // R4 high bit -> bank 0x125 out of range, R9
    wr_at('h3000, 'h01, "R4");
    rd_at('h4000, "R9");
    wr_at('h2ABC, 'h02, "R3");
    rd_at('h4100, "R9");
    wr_at('h3FFF, 'hFE, "R4");
    rd_at('h6000, "R4");
    // R5 bank zero reachable
    wr_at('h2FFF, 'h00, "R5");
    rd_at('h5123, "R5");
    // R9 boundary
    wr_at('h2000, 'h40, "R9");
    rd_at('h4000, "R9");
    rd_at('h0100, "R9");
    wr_at('h2000, 'h3F, "R9");
    rd_at('h7000, "R9");
    // R6 RAM bank, R10 window
    wr_at('h4000, 'h03, "R6");
    rd_at('hBFFF, "R10");
    wr_at('h5FFF, 'hF2, "R6");
    rd_at('hA010, "R10");
    wr_at('hA123, 'h55, "R10");
    rd_at('h9FFF, "R10");
    rd_at('hC000, "R10");
    wr_at('hC000, 'h11, "R10");
    // R11 out-of-range RAM bank
    wr_at('h4000, 'h04, "R11");
    wr_at('hA000, 'h77, "R11");
    rd_at('hB000, "R11");
    wr_at('h4000, 'h0F, "R11");
    rd_at('hA000, "R11");
    wr_at('h4000, 'h01, "R6");
    // R12 writes above 0x6000 ignored
    wr_at('h6000, 'hFF, "R12");
    wr_at('h7FFF, 'h00, "R12");
    wr_at('h8000, 'h0B, "R12");
    wr_at('hE000, 'h00, "R12");
    rd_at('h4004, "R12");
    rd_at('hA004, "R12");
    step(1'b0, 1'b0, 0, 0, "R12");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule